// File: doc/BRIEF.md
# Paged Serial EEPROM Target with Upper-Half Write Protection

This block is a synthesizable two-wire bus target that behaves like a small serial EEPROM. An internal byte array is organized in 16-byte pages. The default configuration holds 256 bytes, and a 512-byte variant is selected by the `ADDR_BITS` parameter.

The block receives oversampled clock and data lines and removes short pulses from both before it detects START, STOP or bits. It answers by pulling the shared data line low through an output enable. A write sends a starting location and then one or more data bytes. These bytes collect in a page buffer and are committed together after STOP, in one internal write cycle that is `WRITE_CYCLES` clocks long. While that cycle runs, the block does not acknowledge its own address, so a controller can poll for completion. A read streams bytes from a location counter that advances after each byte.

A write-protect input blocks commits to the upper half of the array, and the level that counts is the one present at STOP. Tie it low when nothing drives it. The three strap inputs select the bus address. In the 512-byte variant the lowest strap is ignored, and that position of the address byte carries the ninth location bit.

The controller sequences through named states:
- `ST_IDLE` moves to `ST_DEV` on START.
- `ST_DEV` moves to `ST_DEV_ACK` on a matching address while not busy. Otherwise it moves to `ST_SKIP`.
- `ST_DEV_ACK` moves to `ST_WORD` for a write or to `ST_RDAT` for a read.
- `ST_WORD` moves to `ST_WORD_ACK`, then to `ST_WDAT`.
- `ST_WDAT` alternates with `ST_WDAT_ACK`.
- `ST_RDAT` moves to `ST_RD_ACK`. From there it returns to `ST_RDAT` on a controller ACK or moves to `ST_SKIP` on a NACK.
- Any state moves to `ST_DEV` on START and to `ST_IDLE` on STOP.

Top module: `serial_page_mem`

## Requirements
- R1: After reset the data line is released (`sda_pull` = 0) and every array byte reads 0xFF.
- R2: The first byte after START is acknowledged only if its upper nibble is 1010 and bits 3..1 equal `strap[2:0]`. Bit 0 = 0 selects write and bit 0 = 1 selects read. On a mismatch the ninth clock sees the line released.
- R3: In a write, the byte after the address byte sets the location, and every byte is acknowledged (line low in the ninth clock). Data bytes reach the array only after STOP, all in one commit cycle of `WRITE_CYCLES` clocks.
- R4: While a commit cycle runs, the address byte is not acknowledged, even when it matches. Once the cycle ends, it is acknowledged again.
- R5: Data bytes of one write fill consecutive columns of the same page. The column wraps from 15 to 0, so a seventeenth byte overwrites the first one written.
- R6: A read returns the byte at the location counter, MSB first, and then increments the counter. Past the last location it wraps to 0. A controller NACK ends the read.
- R7: The block changes `sda_pull` only while the filtered clock is low, so data is stable during every clock-high phase.
- R8: When `wprot` is high at STOP, a commit to the upper half (location MSB = 1) leaves the array unchanged but is still acknowledged. Commits to the lower half proceed. A change of `wprot` after STOP does not affect the commit in progress.
- R9: Pulses on either line that are shorter than `FILT_LEN` clocks are ignored. They create no extra bit, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap | input | 3 | Bus address strap inputs |
| wprot | input | 1 | High protects the upper half of the array |

## Verification
The write-and-read function is tried with short multi-byte writes, an 18-byte write that overruns its page, and a read that starts two bytes below the top of the array. This separates correct commit from column wrap and from wrap of the whole array. Address bytes that match and that do not match are sent, and a matching byte is also sent while a commit is running. This separates strap decoding from the busy lockout. Protected writes are made to both halves, including one where protection rises only after STOP, which tests when the protect level is sampled. A write carrying sub-threshold pulses on both lines shows that the filter removes them.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RD_ACK,
        ST_SKIP
    } spm_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/spm_deglitch.sv
module spm_deglitch #(
    parameter int  FILT_LEN = 6,
    parameter bit  INIT     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync  <= {2{INIT}};
            cnt   <= '0;
            clean <= INIT;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] != clean) begin
                if (cnt == CW'(FILT_LEN - 1)) begin
                    clean <= sync[1];
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/spm_array.sv
module spm_array #(
    parameter int ADDR_BITS    = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              go,
    input  logic [ADDR_BITS-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic [PAGE_BYTES-1:0]             mask_i,
    input  logic [PAGE_BYTES*8-1:0]           data_i,
    input  logic                              wp_i,
    input  logic [ADDR_BITS-1:0]              rd_addr,
    output logic [7:0]                        rd_data,
    output logic                              busy,
    output logic                              wp_held
);
    localparam int DEPTH     = 1 << ADDR_BITS;
    localparam int COL_BITS  = $clog2(PAGE_BYTES);
    localparam int PAGE_BITS = ADDR_BITS - COL_BITS;
    localparam int TW        = $clog2(WRITE_CYCLES + 1);

    logic [7:0]              mem [DEPTH];
    logic [PAGE_BITS-1:0]    page_q;
    logic [PAGE_BYTES-1:0]   mask_q;
    logic [PAGE_BYTES*8-1:0] data_q;
    logic [TW-1:0]           timer;
    logic                    allow;

    // upper half is locked only when protection was seen at commit start
    assign allow   = !(wp_held && page_q[PAGE_BITS-1]);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            page_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            timer   <= '0;
            busy    <= 1'b0;
            wp_held <= 1'b0;
        end else if (!busy) begin
            if (go) begin
                busy    <= 1'b1;
                timer   <= '0;
                page_q  <= page_i;
                mask_q  <= mask_i;
                data_q  <= data_i;
                wp_held <= wp_i;
            end
        end else if (timer == TW'(WRITE_CYCLES - 1)) begin
            busy <= 1'b0;
            if (allow) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (mask_q[i]) mem[{page_q, COL_BITS'(i)}] <= data_q[i*8 +: 8];
                end
            end
        end else begin
            timer <= timer + TW'(1);
        end
    end
endmodule

// File: rtl/serial_page_mem.sv
module serial_page_mem #(
    parameter int ADDR_BITS    = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int FILT_LEN     = 6,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [2:0] strap,
    input  logic       wprot
);
    import spm_pkg::*;

    localparam int COL_BITS  = $clog2(PAGE_BYTES);
    localparam int PAGE_BITS = ADDR_BITS - COL_BITS;

    logic [1:0] raw_lines, flt_lines;
    logic       scl_f, sda_f, scl_q, sda_q;
    logic       start_c, stop_c, rise_c, fall_c;

    spm_state_e state, nxt;

    logic [3:0]              bitcnt;
    logic [7:0]              rx;
    logic [6:0]              tx;
    logic [ADDR_BITS-1:0]    ptr, word_addr;
    logic [PAGE_BYTES*8-1:0] pbuf;
    logic [PAGE_BYTES-1:0]   pmask;
    logic                    rd_ack, dev_hi, dev_match, commit_go;
    logic                    busy, wp_held;
    logic [7:0]              rd_data;
    logic [COL_BITS-1:0]     col;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        spm_deglitch #(.FILT_LEN(FILT_LEN), .INIT(1'b1)) i_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (flt_lines[g])
        );
    end

    assign scl_f   = flt_lines[0];
    assign sda_f   = flt_lines[1];
    assign start_c = scl_f && scl_q && sda_q && !sda_f;
    assign stop_c  = scl_f && scl_q && !sda_q && sda_f;
    assign rise_c  = scl_f && !scl_q;
    assign fall_c  = !scl_f && scl_q;

    if (ADDR_BITS == 8) begin : g_small
        assign dev_match = (rx[7:4] == DEV_TYPE) && (rx[3:1] == strap);
    end else begin : g_large
        assign dev_match = (rx[7:4] == DEV_TYPE) && (rx[3:2] == strap[2:1]);
    end

    assign word_addr = ADDR_BITS'({dev_hi, rx});
    assign col       = ptr[COL_BITS-1:0];

    spm_array #(
        .ADDR_BITS    (ADDR_BITS),
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (commit_go),
        .page_i  (ptr[ADDR_BITS-1:COL_BITS]),
        .mask_i  (pmask),
        .data_i  (pbuf),
        .wp_i    (wprot),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .busy    (busy),
        .wp_held (wp_held)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = ST_IDLE;
        end else if (start_c) begin
            nxt = ST_DEV;
        end else if (fall_c) begin
            unique case (state)
                ST_DEV:      if (bitcnt == 4'd8) nxt = (dev_match && !busy) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  nxt = rx[0] ? ST_RDAT : ST_WORD;
                ST_WORD:     if (bitcnt == 4'd8) nxt = ST_WORD_ACK;
                ST_WORD_ACK: nxt = ST_WDAT;
                ST_WDAT:     if (bitcnt == 4'd8) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: nxt = ST_WDAT;
                ST_RDAT:     if (bitcnt == 4'd8) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = rd_ack ? ST_RDAT : ST_SKIP;
                ST_IDLE, ST_SKIP: nxt = state;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            sda_pull  <= 1'b0;
            bitcnt    <= '0;
            rx        <= '0;
            tx        <= '0;
            ptr       <= '0;
            pbuf      <= '0;
            pmask     <= '0;
            rd_ack    <= 1'b0;
            dev_hi    <= 1'b0;
            commit_go <= 1'b0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            commit_go <= 1'b0;
            if (stop_c) begin
                sda_pull <= 1'b0;
                if ((state == ST_WDAT || state == ST_WDAT_ACK) && (|pmask)) commit_go <= 1'b1;
            end else if (start_c) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (rise_c) begin
                unique case (state)
                    ST_DEV, ST_WORD, ST_WDAT: begin
                        if (bitcnt < 4'd8) begin
                            rx     <= {rx[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                    ST_RDAT:   if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
                    ST_RD_ACK: rd_ack <= !sda_f;
                    default:   ;
                endcase
            end else if (fall_c) begin
                unique case (state)
                    ST_DEV: begin
                        if (bitcnt == 4'd8) begin
                            dev_hi <= rx[1];
                            if (dev_match && !busy) sda_pull <= 1'b1;
                        end
                    end
                    ST_DEV_ACK: begin
                        bitcnt <= '0;
                        if (rx[0]) begin
                            tx       <= rd_data[6:0];
                            sda_pull <= !rd_data[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_WORD: begin
                        if (bitcnt == 4'd8) begin
                            ptr      <= word_addr;
                            pmask    <= '0;
                            sda_pull <= 1'b1;
                        end
                    end
                    ST_WDAT: begin
                        if (bitcnt == 4'd8) begin
                            pbuf[col*8 +: 8]       <= rx;
                            pmask[col]             <= 1'b1;
                            ptr[COL_BITS-1:0]      <= col + COL_BITS'(1);
                            sda_pull               <= 1'b1;
                        end
                    end
                    ST_WORD_ACK, ST_WDAT_ACK: begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                    end
                    ST_RDAT: begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            ptr      <= ptr + ADDR_BITS'(1);
                        end else begin
                            sda_pull <= !tx[6];
                            tx       <= {tx[5:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        bitcnt <= '0;
                        if (rd_ack) begin
                            tx       <= rd_data[6:0];
                            sda_pull <= !rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_f,
    input logic                sda_pull,
    input logic                busy,
    input logic                wp_held,
    input spm_pkg::spm_state_e state
);
    import spm_pkg::*;

    a_r7_pull_moves_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_f);

    a_r4_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> !busy);

    a_r3_commit_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (state == ST_IDLE));

    a_r3_data_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WORD_ACK || state == ST_WDAT_ACK) |-> sda_pull);

    a_r8_protect_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wp_held));
endmodule

bind serial_page_mem spm_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_pull (sda_pull),
    .busy     (busy),
    .wp_held  (wp_held),
    .state    (state)
);

// File: tb/test_serial_page_mem.sv
module test_serial_page_mem;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 25;
    localparam int WCYC       = 3000;

    typedef struct {
        string req;
        int    val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_tb = 1'b1;
    logic       sda_tb = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wprot = 1'b0;
    logic       sda_pull;
    logic       sda_line;

    item_t      exp_q[$];
    item_t      act_q[$];
    logic [7:0] wbuf[$];
    logic [7:0] rbuf[$];
    int         checks = 0;
    int         fails  = 0;

    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    assign sda_line = sda_tb & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_page_mem #(.WRITE_CYCLES(WCYC)) i_serial_page_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_tb),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .strap    (strap),
        .wprot    (wprot)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                item_t a, e;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                checks++;
                if (a.val != e.val) begin
                    fails++;
                    $display("FAIL %s actual=%0h expected=%0h", e.req, a.val, e.val);
                end
            end
        end
    end

    task automatic bus_start();
        sda_tb = 1'b1; tick(12);
        scl_tb = 1'b1; tick(HB);
        sda_tb = 1'b0; tick(HB);
        scl_tb = 1'b0;
    endtask

    task automatic bus_stop();
        tick(12); sda_tb = 1'b0; tick(13);
        scl_tb = 1'b1; tick(HB);
        sda_tb = 1'b1; tick(HB);
    endtask

    task automatic bit_out(input logic b, input bit glitch);
        tick(12); sda_tb = b;
        if (glitch) begin
            scl_tb = 1'b1; tick(3); scl_tb = 1'b0; tick(10);
        end else begin
            tick(13);
        end
        scl_tb = 1'b1;
        if (glitch && b) begin
            tick(10); sda_tb = 1'b0; tick(3); sda_tb = 1'b1; tick(12);
        end else begin
            tick(HB);
        end
        scl_tb = 1'b0;
    endtask

    task automatic bit_in(output logic v);
        logic late;
        tick(12); sda_tb = 1'b1; tick(13);
        scl_tb = 1'b1; tick(10);
        v = sda_line; tick(12);
        late = sda_line;
        check("R7 data stable in high phase", int'(late), int'(v));
        tick(3);
        scl_tb = 1'b0;
    endtask

    task automatic send_raw(input logic [7:0] b, input bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i], glitch && (i == 5 || i == 2));
        bit_in(ack);
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string req);
        logic a;
        exp_q.push_back('{req, exp_ack});
        send_raw(b, 1'b0, a);
        act_q.push_back('{req, int'(a)});
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit more, input string req);
        logic [7:0] v;
        exp_q.push_back('{req, int'(exp)});
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        act_q.push_back('{req, int'(v)});
        bit_out(!more, 1'b0);
    endtask

    task automatic do_write(input logic [7:0] addr, input string req);
        bus_start();
        send_byte(DEV_W, 0, req);
        send_byte(addr, 0, req);
        foreach (wbuf[i]) send_byte(wbuf[i], 0, req);
        bus_stop();
        wbuf.delete();
    endtask

    task automatic do_read(input logic [7:0] addr, input string req);
        bus_start();
        send_byte(DEV_W, 0, req);
        send_byte(addr, 0, req);
        bus_start();
        send_byte(DEV_R, 0, req);
        foreach (rbuf[i]) read_byte(rbuf[i], i < rbuf.size() - 1, req);
        bus_stop();
        rbuf.delete();
    endtask

    task automatic wait_ready(input string req, output int polls);
        logic a;
        polls = 0;
        a = 1'b1;
        while (a && polls < 40) begin
            bus_start();
            send_raw(DEV_W, 1'b0, a);
            bus_stop();
            polls++;
        end
        check(req, int'(a), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog R3 actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int polls;
        tick(5);
        check("R1 line released after reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        tick(20);
        check("R1 line released after reset", int'(sda_pull), 0);

        // R2: address decode against strap 101
        bus_start(); send_byte(8'hA0, 1, "R2 strap mismatch nack"); bus_stop();
        bus_start(); send_byte(8'hAE, 1, "R2 strap mismatch nack"); bus_stop();

        // R3 / R4: page write, busy lockout, polling
        wbuf = '{8'h11, 8'h22, 8'h33};
        do_write(8'h10, "R3 write acks");
        bus_start(); send_byte(DEV_W, 1, "R4 nack while busy"); bus_stop();
        wait_ready("R4 ack after commit", polls);
        check("R3 commit lasted several polls", int'(polls >= 3), 1);
        rbuf = '{8'hFF, 8'h11, 8'h22, 8'h33, 8'hFF};
        do_read(8'h0F, "R1 R3 R6 readback");

        // R5: 18 bytes from column 14 wrap inside the page
        for (int i = 0; i < 18; i++) wbuf.push_back(8'h40 + 8'(i));
        do_write(8'h2E, "R5 write acks");
        wait_ready("R5 ready", polls);
        for (int c = 0; c < 16; c++) rbuf.push_back(c < 14 ? 8'h42 + 8'(c) : 8'h50 + 8'(c - 14));
        do_read(8'h20, "R5 page wrap contents");

        // R6: wrap from last location to 0
        wbuf = '{8'hA1, 8'hA2};
        do_write(8'hFE, "R6 setup");
        wait_ready("R6 ready", polls);
        wbuf = '{8'hB0};
        do_write(8'h00, "R6 setup");
        wait_ready("R6 ready", polls);
        rbuf = '{8'hA1, 8'hA2, 8'hB0, 8'hFF};
        do_read(8'hFE, "R6 array wrap");

        // R8: protection
        wprot = 1'b1;
        wbuf = '{8'hC5};
        do_write(8'h80, "R8 protected write acked");
        wait_ready("R8 ready", polls);
        wbuf = '{8'hC6};
        do_write(8'h05, "R8 lower half write");
        wait_ready("R8 ready", polls);
        wprot = 1'b0;
        wbuf = '{8'hD7};
        do_write(8'h90, "R8 unprotected at stop");
        wprot = 1'b1;
        wait_ready("R8 ready", polls);
        wprot = 1'b0;
        rbuf = '{8'hFF};
        do_read(8'h80, "R8 upper half unchanged");
        rbuf = '{8'hC6};
        do_read(8'h05, "R8 lower half written");
        rbuf = '{8'hD7};
        do_read(8'h90, "R8 late protect ignored");

        // R9: glitches on both lines during a write
        begin
            logic a;
            bus_start();
            send_raw(DEV_W, 1'b1, a); check("R9 glitched address ack", int'(a), 0);
            send_raw(8'h40, 1'b1, a); check("R9 glitched location ack", int'(a), 0);
            send_raw(8'h5A, 1'b1, a); check("R9 glitched data ack", int'(a), 0);
            bus_stop();
        end
        wait_ready("R9 ready", polls);
        rbuf = '{8'h5A, 8'hFF};
        do_read(8'h40, "R9 glitch-free data");

        wait (act_q.size() == 0);
        tick(10);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule